// File: doc/BRIEF.md
# Write-Leveling Seed Generator

This block computes the starting write-strobe delay for one byte lane before a write-leveling training pass. The training sequencer presents one lane per cycle with the pass number, the module kind, bit 0 of the module's register control word, the current, previous and start-up memory clock speeds, and the delay that the earlier pass trained for that lane. Two cycles later the block returns the lane index with two values. The first is the plain seed, which the caller keeps in its delay table. The second is the seed as loaded into the PHY, re-encoded when the pre-gross mode is on.

The first pass takes a fixed seed chosen by module kind and speed grade, unless the caller supplies an override for the lane. The second pass scales the trained delay by the ratio of the new speed to the old speed. For registered modules, only the part of the delay above the register latency is scaled. Requests that cannot produce a seed are dropped and give no output. This covers a lane index outside the nine lanes, and a second pass with no speed increase or with a zero previous speed.

Top module: `wl_seed_gen`

## Requirements
- R1: While reset is asserted and on the cycles after it, `out_valid` is 0 until a request is accepted. A cycle with `req_valid` at 0 gives `out_valid` at 0 two cycles later.
- R2: A request that is accepted in cycle N gives `out_valid` at 1 in cycle N+2, with `out_lane` equal to the request's lane. A new request may be issued every cycle.
- R3: In the first pass (`req_pass2`=0) with no override, a registered module (`req_dimm`=1) gets seed 0x3B at the slow speed grade (`spd_cur` equal to parameter SPD_SLOW_GRADE, default 333). With `req_cw_bit0`=1 at that grade it gets 0x4B. At any other speed it gets 0x41, or 0x51 with `req_cw_bit0`=1.
- R4: In the first pass with no override, the seed is 0x1A for an unbuffered module (`req_dimm`=0), 0x12 for a small-outline module (`req_dimm`=2) and 0x00 for a load-reduced module (`req_dimm`=3). This holds at every speed and for both values of `req_cw_bit0`.
- R5: In the first pass, `req_ovr_valid`=1 makes the plain seed equal to `req_ovr_seed` for every module kind. In the second pass the override inputs have no effect.
- R6: In the second pass, a registered module gets the plain seed B + floor((old − B) × cur / prev) mod 256. B is 0x20, or 0x30 with `req_cw_bit0`=1. When old is not above B, the difference is taken as 0 and the seed is B.
- R7: In the second pass, every other module kind gets the plain seed floor(old × cur / prev) mod 256.
- R8: With `req_adj_mode`=1, `out_seed` keeps bits 4:0 of the plain seed. Bits 7:5 are 001 when bit 5 of the plain seed is 1, and 010 otherwise. With `req_adj_mode`=0, `out_seed` equals `out_raw`.
- R9: A second-pass request with `spd_cur` not greater than `spd_startup`, or with `spd_prev` equal to 0, is dropped and gives no output.
- R10: Lanes 0 to 7 are data lanes and lane 8 is the ECC lane. All nine are served alike. A request with a lane index of 9 or more is dropped and gives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_lane | input | 4 | Byte lane index, 8 is the ECC lane |
| req_pass2 | input | 1 | 0 for the first pass, 1 for the second pass |
| req_dimm | input | 2 | Module kind: 0 unbuffered, 1 registered, 2 small outline, 3 load reduced |
| req_cw_bit0 | input | 1 | Bit 0 of the module's register control word |
| req_ovr_valid | input | 1 | Override seed present for this lane |
| req_ovr_seed | input | 8 | Override seed value |
| req_adj_mode | input | 1 | Pre-gross re-encoding enable |
| spd_cur | input | 12 | Current memory clock speed |
| spd_prev | input | 12 | Speed of the earlier pass |
| spd_startup | input | 12 | Start-up memory clock speed |
| old_dly | input | 8 | Delay trained in the earlier pass |
| out_valid | output | 1 | Seed result present |
| out_lane | output | 4 | Lane of the result |
| out_raw | output | 8 | Plain seed, for the delay table |
| out_seed | output | 8 | Seed as loaded into the PHY |

## Verification
A wrong seed or a wrong selection in the first stage reaches `out_raw` and `out_seed` exactly two cycles after the request. A wrong valid flag in either stage shows at the same point as a missing or extra output. A fault in the encoder alone differs between `out_raw` and `out_seed` in that same cycle. A bench that compares every cycle against a model therefore localises a fault to the request that caused it. The stimulus covers every module kind, both control-word values, both speed grades, overrides in both passes, the clamp below the register latency, 8-bit wrap of the scaled value, and every drop condition.

// File: rtl/wl_seed_pkg.sv
package wl_seed_pkg;

  localparam int SPD_MAX_W = 16;

  typedef enum logic [1:0] {
    DIMM_UNBUF   = 2'd0,
    DIMM_REG     = 2'd1,
    DIMM_SMALL   = 2'd2,
    DIMM_LOADRED = 2'd3
  } dimm_kind_e;

  localparam logic [7:0] REG_LAT_LO = 8'h20;
  localparam logic [7:0] REG_LAT_HI = 8'h30;

  // First pass: fixed seed by module kind, control-word bit 0 and speed grade.
  function automatic logic [7:0] first_pass_seed(dimm_kind_e kind, logic cw0, logic slow_grade);
    logic [7:0] s;
    unique case (kind)
      DIMM_REG:     s = slow_grade ? (cw0 ? 8'h4B : 8'h3B) : (cw0 ? 8'h51 : 8'h41);
      DIMM_SMALL:   s = 8'h12;
      DIMM_LOADRED: s = 8'h00;
      default:      s = 8'h1A;
    endcase
    return s;
  endfunction

  // Second pass: scale the delay above the register latency by cur/prev.
  function automatic logic [7:0] rescale_seed(logic [7:0] trained,
                                              logic [SPD_MAX_W-1:0] cur,
                                              logic [SPD_MAX_W-1:0] prev,
                                              dimm_kind_e kind, logic cw0);
    logic [7:0] base;
    logic [7:0] span;
    logic [SPD_MAX_W+7:0] prod;
    logic [SPD_MAX_W+7:0] quot;
    base = (kind == DIMM_REG) ? (cw0 ? REG_LAT_HI : REG_LAT_LO) : 8'h00;
    span = (trained > base) ? (trained - base) : 8'h00;
    prod = {{SPD_MAX_W{1'b0}}, span} * {8'h00, cur};
    quot = prod / {8'h00, prev};
    return base + quot[7:0];
  endfunction

  // Pre-gross encoding: odd gross -> 1, even gross -> 2, fine part kept.
  function automatic logic [7:0] pregross_encode(logic [7:0] s);
    return s[5] ? {3'b001, s[4:0]} : {3'b010, s[4:0]};
  endfunction

endpackage

// File: rtl/wl_seed_select.sv
module wl_seed_select
  import wl_seed_pkg::*;
#(
  parameter int NUM_LANES      = 9,
  parameter int LANE_W         = 4,
  parameter int SPD_W          = 12,
  parameter int SPD_SLOW_GRADE = 333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LANE_W-1:0] req_lane,
  input  logic              req_pass2,
  input  logic [1:0]        req_dimm,
  input  logic              req_cw_bit0,
  input  logic              req_ovr_valid,
  input  logic [7:0]        req_ovr_seed,
  input  logic              req_adj_mode,
  input  logic [SPD_W-1:0]  spd_cur,
  input  logic [SPD_W-1:0]  spd_prev,
  input  logic [SPD_W-1:0]  spd_startup,
  input  logic [7:0]        old_dly,
  output logic              s1_vld,
  output logic [LANE_W-1:0] s1_lane,
  output logic [7:0]        s1_raw,
  output logic              s1_adj
);

  dimm_kind_e kind;
  logic       lane_ok;
  logic       pass2_skip;
  logic       accept;
  logic       slow_grade;
  logic [7:0] seed_p1;
  logic [7:0] seed_p2;
  logic [7:0] seed_sel;

  assign kind       = dimm_kind_e'(req_dimm);
  assign lane_ok    = 32'(req_lane) < NUM_LANES;
  assign pass2_skip = req_pass2 && ((spd_cur <= spd_startup) || (spd_prev == '0));
  assign accept     = req_valid && lane_ok && !pass2_skip;
  assign slow_grade = spd_cur == SPD_W'(SPD_SLOW_GRADE);

  assign seed_p1  = req_ovr_valid ? req_ovr_seed
                                  : first_pass_seed(kind, req_cw_bit0, slow_grade);
  assign seed_p2  = rescale_seed(old_dly, SPD_MAX_W'(spd_cur), SPD_MAX_W'(spd_prev),
                                 kind, req_cw_bit0);
  assign seed_sel = req_pass2 ? seed_p2 : seed_p1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_lane <= '0;
      s1_raw  <= '0;
      s1_adj  <= 1'b0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_lane <= req_lane;
        s1_raw  <= seed_sel;
        s1_adj  <= req_adj_mode;
      end
    end
  end

  // R9
  pass2_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pass2 && (spd_cur <= spd_startup)) |=> !s1_vld);

  // R10
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lane_ok) |=> !s1_vld);

endmodule

// File: rtl/wl_seed_encode.sv
module wl_seed_encode
  import wl_seed_pkg::*;
#(
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_vld,
  input  logic [LANE_W-1:0] s1_lane,
  input  logic [7:0]        s1_raw,
  input  logic              s1_adj,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_lane,
  output logic [7:0]        out_raw,
  output logic [7:0]        out_seed
);

  logic [7:0] enc_seed;
  assign enc_seed = s1_adj ? pregross_encode(s1_raw) : s1_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_raw   <= '0;
      out_seed  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_lane <= s1_lane;
        out_raw  <= s1_raw;
        out_seed <= enc_seed;
      end
    end
  end

  // R2
  stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> (out_valid && out_lane == $past(s1_lane)));

  // R1
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid);

  // R8
  fine_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_seed[4:0] == out_raw[4:0]));

endmodule

// File: rtl/wl_seed_gen.sv
module wl_seed_gen
  import wl_seed_pkg::*;
#(
  parameter int NUM_LANES      = 9,
  parameter int LANE_W         = $clog2(NUM_LANES),
  parameter int SPD_W          = 12,
  parameter int SPD_SLOW_GRADE = 333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LANE_W-1:0] req_lane,
  input  logic              req_pass2,
  input  logic [1:0]        req_dimm,
  input  logic              req_cw_bit0,
  input  logic              req_ovr_valid,
  input  logic [7:0]        req_ovr_seed,
  input  logic              req_adj_mode,
  input  logic [SPD_W-1:0]  spd_cur,
  input  logic [SPD_W-1:0]  spd_prev,
  input  logic [SPD_W-1:0]  spd_startup,
  input  logic [7:0]        old_dly,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_lane,
  output logic [7:0]        out_raw,
  output logic [7:0]        out_seed
);

  logic              s1_vld;
  logic [LANE_W-1:0] s1_lane;
  logic [7:0]        s1_raw;
  logic              s1_adj;

  wl_seed_select #(
    .NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .SPD_W(SPD_W), .SPD_SLOW_GRADE(SPD_SLOW_GRADE)
  ) u_select (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane(req_lane),
    .req_pass2(req_pass2), .req_dimm(req_dimm), .req_cw_bit0(req_cw_bit0),
    .req_ovr_valid(req_ovr_valid), .req_ovr_seed(req_ovr_seed), .req_adj_mode(req_adj_mode),
    .spd_cur(spd_cur), .spd_prev(spd_prev), .spd_startup(spd_startup), .old_dly(old_dly),
    .s1_vld(s1_vld), .s1_lane(s1_lane), .s1_raw(s1_raw), .s1_adj(s1_adj)
  );

  wl_seed_encode #(.LANE_W(LANE_W)) u_encode (
    .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .s1_lane(s1_lane), .s1_raw(s1_raw),
    .s1_adj(s1_adj), .out_valid(out_valid), .out_lane(out_lane), .out_raw(out_raw),
    .out_seed(out_seed)
  );

  // R10
  out_lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_lane) < NUM_LANES));

endmodule

// File: tb/wl_seed_gen_tb_top.sv
module wl_seed_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 0, req_pass2 = 0, req_cw_bit0 = 0, req_ovr_valid = 0, req_adj_mode = 0;
  logic [3:0] req_lane = 0;
  logic [1:0] req_dimm = 0;
  logic [7:0] req_ovr_seed = 0, old_dly = 0;
  logic [11:0] spd_cur = 0, spd_prev = 0, spd_startup = 0;
  logic       out_valid;
  logic [3:0] out_lane;
  logic [7:0] out_raw, out_seed;

  always #10 clk = ~clk;

  wl_seed_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane(req_lane),
    .req_pass2(req_pass2), .req_dimm(req_dimm), .req_cw_bit0(req_cw_bit0),
    .req_ovr_valid(req_ovr_valid), .req_ovr_seed(req_ovr_seed), .req_adj_mode(req_adj_mode),
    .spd_cur(spd_cur), .spd_prev(spd_prev), .spd_startup(spd_startup), .old_dly(old_dly),
    .out_valid(out_valid), .out_lane(out_lane), .out_raw(out_raw), .out_seed(out_seed)
  );

  typedef struct {
    bit    vld;
    int    lane;
    int    raw;
    int    seed;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Behavioural reference for one request.
  function automatic exp_t model(bit v, int lane, bit p2, int dimm, bit cw, bit ov, int ovs,
                                 bit adj, int cur, int prev, int st, int old);
    exp_t e;
    int b, d;
    e.vld = 0; e.lane = lane; e.raw = 0; e.seed = 0; e.tag = "R1";
    if (!v) return e;
    if (lane > 8) begin e.tag = "R10"; return e; end
    if (p2 && (cur <= st || prev == 0)) begin e.tag = "R9"; return e; end
    e.vld = 1;
    if (!p2) begin
      if (ov) begin e.raw = ovs; e.tag = "R5"; end
      else if (dimm == 1) begin
        e.tag = "R3";
        if (cur == 333) e.raw = cw ? 'h4B : 'h3B;
        else            e.raw = cw ? 'h51 : 'h41;
      end else begin
        e.tag = "R4";
        e.raw = (dimm == 2) ? 'h12 : (dimm == 3) ? 'h00 : 'h1A;
      end
    end else begin
      b = (dimm == 1) ? (cw ? 48 : 32) : 0;
      d = (old > b) ? old - b : 0;
      e.raw = (b + (d * cur) / prev) % 256;
      e.tag = (dimm == 1) ? "R6" : "R7";
      if (ov) e.tag = {e.tag, "/R5"};
    end
    if (adj) begin
      e.seed = (e.raw % 32) + (((e.raw / 32) % 2 == 1) ? 32 : 64);
      e.tag = {e.tag, "/R8"};
    end else e.seed = e.raw;
    if (lane == 8) e.tag = {e.tag, "/R10"};
    return e;
  endfunction

  task automatic chk(string tag, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // One cycle: drive, wait a negedge, compare the result of two drives ago (R2 latency).
  task automatic step(bit v, int lane, bit p2, int dimm, bit cw, bit ov, int ovs,
                      bit adj, int cur, int prev, int st, int old);
    exp_t e;
    req_valid = v; req_lane = 4'(lane); req_pass2 = p2; req_dimm = 2'(dimm);
    req_cw_bit0 = cw; req_ovr_valid = ov; req_ovr_seed = 8'(ovs); req_adj_mode = adj;
    spd_cur = 12'(cur); spd_prev = 12'(prev); spd_startup = 12'(st); old_dly = 8'(old);
    exp_q.push_back(model(v, lane, p2, dimm, cw, ov, ovs, adj, cur, prev, st, old));
    @(negedge clk);
    e = exp_q.pop_front();
    chk({e.tag, "/R2"}, "valid", int'(out_valid), int'(e.vld));
    if (e.vld && out_valid) begin
      chk({e.tag, "/R2"}, "lane", int'(out_lane), e.lane);
      chk(e.tag, "raw", int'(out_raw), e.raw);
      chk(e.tag, "seed", int'(out_seed), e.seed);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    begin
      exp_t e0;
      e0.vld = 0; e0.lane = 0; e0.raw = 0; e0.seed = 0; e0.tag = "R1";
      exp_q.push_back(e0);
    end
    idle(); idle();
    // R3: registered defaults, both grades, both control-word values
    step(1, 0, 0, 1, 0, 0, 0, 0, 333, 0, 333, 0);
    step(1, 1, 0, 1, 1, 0, 0, 0, 333, 0, 333, 0);
    step(1, 2, 0, 1, 0, 0, 0, 0, 400, 0, 400, 0);
    step(1, 3, 0, 1, 1, 0, 0, 1, 400, 0, 400, 0);
    // R4: other kinds, cw bit must not matter
    for (int k = 0; k < 2; k++) begin
      step(1, 4, 0, 0, k[0], 0, 0, 0, 333, 0, 333, 0);
      step(1, 5, 0, 2, k[0], 0, 0, 0, 400, 0, 400, 0);
      step(1, 8, 0, 3, k[0], 0, 0, 1, 533, 0, 400, 0);
    end
    // R5: override in pass 1, ignored in pass 2
    step(1, 6, 0, 1, 1, 1, 'h77, 0, 333, 0, 333, 0);
    step(1, 7, 0, 0, 0, 1, 'h25, 1, 400, 0, 400, 0);
    step(1, 7, 1, 0, 0, 1, 'h99, 0, 533, 400, 400, 'h20);
    // R6: registered scaling, clamp below latency
    step(1, 0, 1, 1, 0, 0, 0, 0, 533, 400, 400, 'h41);
    step(1, 1, 1, 1, 1, 0, 0, 1, 667, 400, 400, 'h51);
    step(1, 2, 1, 1, 1, 0, 0, 0, 800, 400, 400, 'h28);
    step(1, 3, 1, 1, 0, 0, 0, 0, 800, 333, 333, 'hFF);
    // R7: unbuffered / small / load reduced, 8-bit wrap
    step(1, 4, 1, 0, 0, 0, 0, 0, 800, 400, 400, 'hF0);
    step(1, 5, 1, 2, 1, 0, 0, 1, 533, 400, 400, 'h12);
    step(1, 8, 1, 3, 0, 0, 0, 1, 667, 400, 400, 'h3F);
    // R9: skip conditions
    step(1, 1, 1, 0, 0, 0, 0, 0, 400, 400, 400, 'h30);
    step(1, 1, 1, 1, 0, 0, 0, 0, 333, 400, 400, 'h30);
    step(1, 1, 1, 0, 0, 0, 0, 0, 533, 0, 400, 'h30);
    // R10: lanes beyond the ECC lane
    step(1, 9, 0, 0, 0, 0, 0, 0, 400, 0, 400, 0);
    step(1, 15, 1, 1, 0, 0, 0, 0, 533, 400, 400, 'h41);
    // R8: sweep encoding over many plain seeds via override
    for (int s = 0; s < 256; s += 7) step(1, s % 9, 0, 0, 0, 1, s, s % 2, 400, 0, 400, 0);
    idle(); idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule